// File: doc/BRIEF.md
# Power Delivery Transmit Buffer Controller

This block is the transmit side of a USB Power Delivery PHY. Software fills a byte buffer with a two-byte message header and up to 28 payload bytes over a byte-wide register bus. It then programs a size register with the byte count minus one. A write to the command register then starts either a full message or a single-beat signal such as a hard reset or a cable reset. The block hands the message bytes, in buffer order, to a downstream line coder through a valid/ready handshake.

After the last byte of a message leaves, the block waits a bounded number of cycles for an acknowledge from the receive side. If none comes, it replays the whole message, up to the programmed retry count. Every transfer ends in exactly one completion event: message sent, message failed, transfer discarded, or signal sent. An incoming message seen before the first byte of an attempt is accepted discards the transfer. A write of zero to the command register abandons any transfer in progress.

Top module: `pd_tx_ctrl`

## Requirements
- R1: After reset the block is idle: `tx_valid` is low, no event is raised, and the command register reads 0.
- R2: The command register (address 0x20) reads back the last value written to it, and the size register (address 0x21) reads back its 5-bit value in bits 4:0.
- R3: A message sends min(size+1, 30) bytes in order. Buffer offset 0x60 and 0x61 hold the header, and payload bytes start at 0x62. `tx_last` is high only on the final byte.
- R4: Command bit 0 starts a message and bit 1 starts a signal, and only on a 0-to-1 change of that bit while the block is idle. Rewriting a bit that is already set starts nothing.
- R5: An `ack_in` pulse while waiting after the last byte raises `ev_sent` for one cycle, and the block returns to idle.
- R6: With no acknowledge for ACK_WAIT cycles after the last byte, the message is sent again from byte 0. After retry+1 attempts, where retry is command bits 6:5, `ev_failed` is raised.
- R7: A signal is one beat with `tx_signal` and `tx_last` high and the frame type (command bits 4:2) in `tx_data[2:0]`. `ev_sig_sent` rises in the cycle after it is accepted, with no acknowledge wait.
- R8: If `rx_detect` is high while the first byte of an attempt is still pending, `tx_valid` is low in that cycle, `ev_discarded` is raised next cycle, and the block goes idle. `rx_detect` after the first byte has been accepted has no effect.
- R9: Writing zero to the command register ends any transfer. `tx_valid` is low from the next cycle, and no completion event follows.
- R10: Completion events are single-cycle pulses, at most one at a time, and each transfer raises exactly one.
- R11: While `tx_valid` is high and `tx_ready` is low, `tx_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for `bus_addr` |
| tx_valid | output | 1 | Byte or signal beat offered to the line coder |
| tx_ready | input | 1 | Line coder accepts the beat |
| tx_data | output | 8 | Message byte, or frame type for a signal |
| tx_last | output | 1 | Final beat of the attempt |
| tx_signal | output | 1 | Beat is a bare signal |
| rx_detect | input | 1 | Incoming message seen on the line |
| ack_in | input | 1 | Acknowledge received for the last message |
| ev_sent | output | 1 | Message acknowledged |
| ev_failed | output | 1 | Retries exhausted |
| ev_discarded | output | 1 | Transfer dropped because of incoming traffic |
| ev_sig_sent | output | 1 | Signal beat delivered |

## Verification
The handshake-hold property assumes that software leaves the transmit buffer and the size register alone while a transfer is active. The stimulus therefore writes the buffer and the size only while the block is idle. The acknowledge-cause and discard-cause properties assume `ack_in` and `rx_detect` are synchronous, single-clock inputs. The bench drives them only at falling edges, and it pulses `ack_in` once, a few cycles into the wait window.

// File: rtl/pd_tx_pkg.sv
package pd_tx_pkg;

  localparam int BYTE_W       = 8;
  localparam int CTL_MSG_BIT  = 0;
  localparam int CTL_SIG_BIT  = 1;
  localparam int CTL_TYPE_LO  = 2;
  localparam int CTL_RETRY_LO = 5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } eng_state_t;

  // bytes sent for a programmed size value, limited by the buffer capacity
  function automatic int unsigned beats_for_size(input int unsigned sz,
                                                 input int unsigned cap);
    return (sz + 1 > cap) ? cap : sz + 1;
  endfunction

  // true once the attempts already replayed reach the programmed retry limit
  function automatic logic retries_spent(input logic [1:0] done_cnt,
                                         input logic [1:0] limit);
    return done_cnt >= limit;
  endfunction

endpackage

// File: rtl/pd_tx_regfile.sv
module pd_tx_regfile
  import pd_tx_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BUF_BYTES = 30,
  parameter int BUF_BASE  = 96,
  parameter int CTRL_ADDR = 32,
  parameter int SIZE_ADDR = 33,
  parameter int IDX_W     = $clog2(BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              eng_idle,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              start_msg,
  output logic              start_sig,
  output logic              abort,
  output logic [2:0]        cmd_type,
  output logic [1:0]        cmd_retry,
  output logic [IDX_W-1:0]  size_q
);

  logic [BYTE_W-1:0] ctrl_q;
  logic [BYTE_W-1:0] buf_q [BUF_BYTES];
  logic              ctrl_hit, size_hit;

  assign ctrl_hit = (bus_addr == ADDR_W'(CTRL_ADDR));
  assign size_hit = (bus_addr == ADDR_W'(SIZE_ADDR));

  // one storage byte per buffer slot
  for (genvar g = 0; g < BUF_BYTES; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        buf_q[g] <= '0;
      else if (bus_we && bus_addr == ADDR_W'(BUF_BASE + g))
        buf_q[g] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      size_q <= '0;
    end else if (bus_we) begin
      if (ctrl_hit) ctrl_q <= bus_wdata;
      if (size_hit) size_q <= bus_wdata[IDX_W-1:0];
    end
  end

  // command decode works on the incoming write so the engine starts at that edge
  assign start_msg = bus_we && ctrl_hit && eng_idle &&
                     bus_wdata[CTL_MSG_BIT] && !ctrl_q[CTL_MSG_BIT];
  assign start_sig = bus_we && ctrl_hit && eng_idle && !start_msg &&
                     bus_wdata[CTL_SIG_BIT] && !ctrl_q[CTL_SIG_BIT];
  assign abort     = bus_we && ctrl_hit && (bus_wdata == '0);
  assign cmd_type  = bus_wdata[CTL_TYPE_LO +: 3];
  assign cmd_retry = bus_wdata[CTL_RETRY_LO +: 2];

  assign rd_byte = (32'(rd_idx) < BUF_BYTES) ? buf_q[rd_idx] : '0;

  always_comb begin
    bus_rdata = '0;
    if (ctrl_hit)
      bus_rdata = ctrl_q;
    else if (size_hit)
      bus_rdata[IDX_W-1:0] = size_q;
  end

endmodule

// File: rtl/pd_tx_ack_timer.sv
module pd_tx_ack_timer #(
  parameter int ACK_WAIT = 16,
  parameter int CNT_W    = $clog2(ACK_WAIT)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (!run || expired)
      cnt_q <= '0;
    else
      cnt_q <= cnt_q + 1'b1;
  end

  assign expired = run && (cnt_q == CNT_W'(ACK_WAIT - 1));

endmodule

// File: rtl/pd_tx_engine.sv
module pd_tx_engine
  import pd_tx_pkg::*;
#(
  parameter int BUF_BYTES = 30,
  parameter int ACK_WAIT  = 16,
  parameter int IDX_W     = $clog2(BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_msg,
  input  logic              start_sig,
  input  logic              abort,
  input  logic [2:0]        cmd_type,
  input  logic [1:0]        cmd_retry,
  input  logic [IDX_W-1:0]  size_q,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_last,
  output logic              tx_signal,
  input  logic              rx_detect,
  input  logic              ack_in,
  output logic              ev_sent,
  output logic              ev_failed,
  output logic              ev_discarded,
  output logic              ev_sig_sent,
  output logic              idle,
  output logic              discard_now,
  output logic              ack_timeout
);

  eng_state_t       state_q;
  logic [IDX_W-1:0] idx_q, last_q;
  logic             sig_q;
  logic [2:0]       type_q;
  logic [1:0]       retry_q, tries_q;
  logic             beat_taken;

  pd_tx_ack_timer #(.ACK_WAIT(ACK_WAIT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (state_q == ST_WAIT),
    .expired (ack_timeout)
  );

  assign idle        = (state_q == ST_IDLE);
  assign discard_now = (state_q == ST_SEND) && (idx_q == '0) && rx_detect;
  assign tx_valid    = (state_q == ST_SEND) && !discard_now;
  assign beat_taken  = tx_valid && tx_ready;
  assign tx_signal   = sig_q;
  assign tx_last     = sig_q || (idx_q == last_q);
  assign tx_data     = sig_q ? {{(BYTE_W-3){1'b0}}, type_q} : rd_byte;
  assign rd_idx      = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      idx_q        <= '0;
      last_q       <= '0;
      sig_q        <= 1'b0;
      type_q       <= '0;
      retry_q      <= '0;
      tries_q      <= '0;
      ev_sent      <= 1'b0;
      ev_failed    <= 1'b0;
      ev_discarded <= 1'b0;
      ev_sig_sent  <= 1'b0;
    end else begin
      ev_sent      <= 1'b0;
      ev_failed    <= 1'b0;
      ev_discarded <= 1'b0;
      ev_sig_sent  <= 1'b0;
      if (abort) begin
        state_q <= ST_IDLE;
      end else begin
        unique case (state_q)
          ST_IDLE: begin
            if (start_msg || start_sig) begin
              state_q <= ST_SEND;
              idx_q   <= '0;
              sig_q   <= start_sig;
              type_q  <= cmd_type;
              retry_q <= cmd_retry;
              tries_q <= '0;
              last_q  <= IDX_W'(beats_for_size(32'(size_q), BUF_BYTES) - 1);
            end
          end
          ST_SEND: begin
            if (discard_now) begin
              ev_discarded <= 1'b1;
              state_q      <= ST_IDLE;
            end else if (beat_taken) begin
              if (tx_last) begin
                if (sig_q) begin
                  ev_sig_sent <= 1'b1;
                  state_q     <= ST_IDLE;
                end else begin
                  state_q <= ST_WAIT;
                end
              end else begin
                idx_q <= idx_q + 1'b1;
              end
            end
          end
          ST_WAIT: begin
            if (ack_in) begin
              ev_sent <= 1'b1;
              state_q <= ST_IDLE;
            end else if (ack_timeout) begin
              if (retries_spent(tries_q, retry_q)) begin
                ev_failed <= 1'b1;
                state_q   <= ST_IDLE;
              end else begin
                tries_q <= tries_q + 1'b1;
                idx_q   <= '0;
                state_q <= ST_SEND;
              end
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/pd_tx_ctrl.sv
module pd_tx_ctrl
  import pd_tx_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BUF_BYTES = 30,
  parameter int BUF_BASE  = 96,
  parameter int CTRL_ADDR = 32,
  parameter int SIZE_ADDR = 33,
  parameter int ACK_WAIT  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  output logic              tx_signal,
  input  logic              rx_detect,
  input  logic              ack_in,
  output logic              ev_sent,
  output logic              ev_failed,
  output logic              ev_discarded,
  output logic              ev_sig_sent
);

  localparam int IDX_W = $clog2(BUF_BYTES);

  logic             start_msg_w, start_sig_w, abort_w, idle_w;
  logic             discard_w, timeout_w;
  logic [2:0]       type_w;
  logic [1:0]       retry_w;
  logic [IDX_W-1:0] size_w, idx_w;
  logic [7:0]       byte_w;

  pd_tx_regfile #(
    .ADDR_W(ADDR_W), .BUF_BYTES(BUF_BYTES), .BUF_BASE(BUF_BASE),
    .CTRL_ADDR(CTRL_ADDR), .SIZE_ADDR(SIZE_ADDR)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .eng_idle  (idle_w),
    .rd_idx    (idx_w),
    .rd_byte   (byte_w),
    .start_msg (start_msg_w),
    .start_sig (start_sig_w),
    .abort     (abort_w),
    .cmd_type  (type_w),
    .cmd_retry (retry_w),
    .size_q    (size_w)
  );

  pd_tx_engine #(.BUF_BYTES(BUF_BYTES), .ACK_WAIT(ACK_WAIT)) u_engine (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_msg    (start_msg_w),
    .start_sig    (start_sig_w),
    .abort        (abort_w),
    .cmd_type     (type_w),
    .cmd_retry    (retry_w),
    .size_q       (size_w),
    .rd_idx       (idx_w),
    .rd_byte      (byte_w),
    .tx_valid     (tx_valid),
    .tx_ready     (tx_ready),
    .tx_data      (tx_data),
    .tx_last      (tx_last),
    .tx_signal    (tx_signal),
    .rx_detect    (rx_detect),
    .ack_in       (ack_in),
    .ev_sent      (ev_sent),
    .ev_failed    (ev_failed),
    .ev_discarded (ev_discarded),
    .ev_sig_sent  (ev_sig_sent),
    .idle         (idle_w),
    .discard_now  (discard_w),
    .ack_timeout  (timeout_w)
  );

endmodule

// File: rtl/pd_tx_chk.sv
module pd_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       tx_last,
  input logic       tx_signal,
  input logic       rx_detect,
  input logic       ack_in,
  input logic       ev_sent,
  input logic       ev_failed,
  input logic       ev_discarded,
  input logic       ev_sig_sent,
  input logic       abort_w,
  input logic       start_w,
  input logic       idle_w
);

  // R10
  one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_sent, ev_failed, ev_discarded, ev_sig_sent}));

  // R10
  event_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sent || ev_failed || ev_discarded || ev_sig_sent) |-> idle_w);

  // R11
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !abort_w) |=> $stable(tx_data));

  // R9
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_w |=> (!tx_valid && !ev_sent && !ev_failed && !ev_sig_sent));

  // R8
  discard_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_discarded |-> $past(rx_detect));

  // R5
  sent_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sent |-> $past(ack_in));

  // R4
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_w |=> !idle_w);

  // R7
  signal_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_signal) |-> tx_last);

endmodule

bind pd_tx_ctrl pd_tx_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tx_valid     (tx_valid),
  .tx_ready     (tx_ready),
  .tx_data      (tx_data),
  .tx_last      (tx_last),
  .tx_signal    (tx_signal),
  .rx_detect    (rx_detect),
  .ack_in       (ack_in),
  .ev_sent      (ev_sent),
  .ev_failed    (ev_failed),
  .ev_discarded (ev_discarded),
  .ev_sig_sent  (ev_sig_sent),
  .abort_w      (abort_w),
  .start_w      (start_msg_w || start_sig_w),
  .idle_w       (idle_w)
);

// File: tb/pd_tx_ctrl_bench.sv
`timescale 1ns/1ps
module pd_tx_ctrl_bench;

  localparam int ACK_W  = 8;
  localparam int CAP    = 30;
  localparam logic [7:0] A_CTRL = 8'h20;
  localparam logic [7:0] A_SIZE = 8'h21;
  localparam logic [7:0] A_BUF  = 8'h60;

  typedef struct packed {
    logic [4:0] size;
    logic [1:0] retry;
    logic [2:0] ack_att;   // attempt that gets acknowledged, 0 = never
    logic       stall;
    logic [1:0] outcome;   // 0 sent, 1 failed
    logic [2:0] attempts;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{5'd1,  2'd3, 3'd1, 1'b0, 2'd0, 3'd1},
    '{5'd5,  2'd2, 3'd2, 1'b0, 2'd0, 3'd2},
    '{5'd29, 2'd0, 3'd0, 1'b0, 2'd1, 3'd1},
    '{5'd9,  2'd1, 3'd0, 1'b1, 2'd1, 3'd2},
    '{5'd31, 2'd0, 3'd1, 1'b1, 2'd0, 3'd1},
    '{5'd3,  2'd3, 3'd0, 1'b0, 2'd1, 3'd4}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic tx_valid, tx_ready = 1'b0, tx_last, tx_signal;
  logic [7:0] tx_data;
  logic rx_detect = 1'b0, ack_in = 1'b0;
  logic ev_sent, ev_failed, ev_discarded, ev_sig_sent;

  int n_chk = 0, n_fail = 0;
  bit reported = 1'b0;

  always #2 clk = ~clk;

  pd_tx_ctrl #(.ACK_WAIT(ACK_W)) u_pd_tx_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .tx_signal(tx_signal), .rx_detect(rx_detect), .ack_in(ack_in),
    .ev_sent(ev_sent), .ev_failed(ev_failed), .ev_discarded(ev_discarded),
    .ev_sig_sent(ev_sig_sent)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!reported) begin
      reported = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 37 + i * 11 + 5) ^ (i << 3));
  endfunction

  // called at a falling edge, returns at the next falling edge
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic int evs();
    return int'(ev_sent) + int'(ev_failed) + int'(ev_discarded) + int'(ev_sig_sent);
  endfunction

  task automatic run_vec(input int k);
    int beats, bidx, attempts, ack_cd, n_ev, outc, bad, after;
    vec_t v;
    v = VECS[k];
    beats = (int'(v.size) + 1 > CAP) ? CAP : int'(v.size) + 1;
    for (int i = 0; i < CAP; i++) wr(A_BUF + 8'(i), pat(k, i));
    wr(A_SIZE, {3'b0, v.size});
    wr(A_CTRL, 8'h00);
    wr(A_CTRL, {1'b0, v.retry, 3'b000, 1'b0, 1'b1});
    bidx = 0; attempts = 0; ack_cd = 0; n_ev = 0; outc = -1; bad = 0; after = -1;
    for (int c = 0; c < 2000 && after != 0; c++) begin
      tx_ready = v.stall ? (c % 3 != 0) : 1'b1;
      ack_in   = (ack_cd == 1);
      if (ack_cd > 0) ack_cd--;
      #1;
      if (evs() != 0) begin
        n_ev += evs();
        if (ev_sent) outc = 0;
        else if (ev_failed) outc = 1;
        else outc = 2;
        if (after < 0) after = 4;
      end
      if (tx_valid) begin
        if (tx_data != pat(k, bidx) || tx_last != (bidx == beats - 1)) bad++;
        if (tx_ready) begin
          if (bidx == 0) attempts++;
          if (bidx == beats - 1) begin
            bidx = 0;
            if (attempts == int'(v.ack_att)) ack_cd = 3;
          end else bidx++;
        end
      end
      if (after > 0) after--;
      @(negedge clk);
    end
    tx_ready = 1'b0; ack_in = 1'b0;
    check(bad == 0, $sformatf("R3 vec%0d byte order/last", k), bad, 0);
    check(outc == int'(v.outcome), $sformatf("R5/R6 vec%0d outcome", k), outc, int'(v.outcome));
    check(attempts == int'(v.attempts), $sformatf("R6 vec%0d attempts", k), attempts, int'(v.attempts));
    check(n_ev == 1, $sformatf("R10 vec%0d event count", k), n_ev, 1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin : main
    logic [7:0] r;
    int seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(A_CTRL, r);
    check(r == 8'h00, "R1 ctrl after reset", r, 0);
    check(!tx_valid && evs() == 0, "R1 idle outputs", int'(tx_valid) + evs(), 0);

    // R2 readback, and no start without a start bit (R4)
    @(negedge clk);
    wr(A_SIZE, 8'h0d);
    rd(A_SIZE, r);
    check(r == 8'h0d, "R2 size readback", r, 8'h0d);
    wr(A_CTRL, 8'h60);
    rd(A_CTRL, r);
    check(r == 8'h60, "R2 ctrl readback", r, 8'h60);
    check(!tx_valid, "R4 no start bit", int'(tx_valid), 0);
    @(negedge clk);

    for (int k = 0; k < 6; k++) run_vec(k);

    // R4 rewrite of an already-set start bit does nothing
    wr(A_CTRL, 8'h61);
    seen = 0;
    for (int c = 0; c < 5; c++) begin
      if (tx_valid) seen++;
      @(negedge clk);
    end
    check(seen == 0, "R4 rewrite start no edge", seen, 0);

    // R7 reset-type signal
    wr(A_CTRL, 8'h00);
    wr(A_CTRL, 8'h46);
    #1;
    check(tx_valid && tx_signal && tx_last && tx_data == 8'h01, "R7 signal beat",
          int'(tx_data), 1);
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
    #1;
    check(ev_sig_sent && !tx_valid, "R7 signal sent event", int'(ev_sig_sent), 1);
    @(negedge clk);

    // R8 discard before the first byte
    wr(A_SIZE, 8'h03);
    wr(A_CTRL, 8'h00);
    wr(A_CTRL, 8'h01);
    rx_detect = 1'b1;
    #1;
    check(!tx_valid, "R8 valid gated by rx_detect", int'(tx_valid), 0);
    @(negedge clk);
    rx_detect = 1'b0;
    #1;
    check(ev_discarded && !tx_valid, "R8 discarded event", int'(ev_discarded), 1);
    @(negedge clk);

    // R8 rx_detect after the first byte has no effect
    wr(A_CTRL, 8'h00);
    wr(A_CTRL, 8'h01);
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
    rx_detect = 1'b1;
    #1;
    check(tx_valid && tx_data == pat(5, 1), "R8 late rx_detect ignored", int'(tx_valid), 1);
    @(negedge clk);
    rx_detect = 1'b0;
    check(!ev_discarded && tx_valid, "R8 no discard after first byte", int'(ev_discarded), 0);

    // R9 abort mid-transfer
    tx_ready = 1'b1;
    wr(A_CTRL, 8'h00);
    #1;
    check(!tx_valid, "R9 valid drops after abort", int'(tx_valid), 0);
    seen = 0;
    for (int c = 0; c < 3 * ACK_W; c++) begin
      seen += evs() + int'(tx_valid);
      @(negedge clk);
    end
    tx_ready = 1'b0;
    check(seen == 0, "R9 no event after abort", seen, 0);

    summary();
    $finish;
  end

endmodule